// File: doc/BRIEF.md
# Power Supervisor Sequencer

This block turns three digitized supply-level flags into the control signals a processor core needs while its main rail sags, fails and recovers. The flags report, from the mildest to the most severe, that the supply is under the early-warning level, under the minimum operating level, and under the level at which the battery must take over. The analog reference, the comparators and the supply switch sit outside the block. It only sequences their results.

The flags are first reduced to one severity value. A warning on its own raises a sticky power-fail interrupt request carrying a fixed vector, and the processor keeps executing. Crossing the minimum level holds the processor in reset and forces every memory chip enable and the read/write strobe to their inactive high level. Crossing the battery level also selects the battery source. When the supply recovers, or when the external reset input is released, the processor is kept in reset for a power-on delay counted in oscillator clocks. Only after that delay are the strobes handed back to the core.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rstN` is low and for as long as the power-on delay has not run out after it, `procReset` is 1, `pfIrq` is 0, `pfVector` is 0, every bit of `ceOut` is 1 and `rwOut` is 1.
- R2: With `warnIntEn`=1, the processor out of reset and only `belowWarn` set, `pfIrq` goes to 1 at the next rising clock edge and `pfVector` then reads `IRQ_VECTOR` (default 8'h2B). `procReset` stays 0.
- R3: With `warnIntEn`=0 a warning leaves `pfIrq` at 0, and `pfVector` is 0 whenever `pfIrq` is 0.
- R4: Once set, `pfIrq` stays at 1 after the warning flag clears. A cycle with `intClr`=1 clears it at that edge, unless the warning condition is still present, in which case it stays set.
- R5: `belowMin` or `belowBat` drives `procReset` to 1 in the same cycle, without waiting for a clock edge. At the next edge a pending `pfIrq` is cleared.
- R6: While `procReset` is 1, `ceOut` is all ones and `rwOut` is 1. Otherwise `ceOut` equals `ceIn` and `rwOut` equals `rwIn`.
- R7: `batSel` is 1 exactly while `belowBat` is 1. Between the minimum and battery levels it stays 0.
- R8: After the last hold cause (`belowMin`, `belowBat`, `extRst`) drops, `procReset` stays 1 through `POR_CYCLES`-1 rising edges and falls after the `POR_CYCLES`-th.
- R9: `extRst`=1 holds `procReset` at 1. Asserting it during a running delay restarts the full `POR_CYCLES` count.
- R10: Flags out of order are treated as the most severe flag set. `belowBat` alone gives battery selection plus reset, and `belowMin` alone gives reset with no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| belowWarn | input | 1 | Supply under the early-warning level |
| belowMin | input | 1 | Supply under the minimum operating level |
| belowBat | input | 1 | Supply under the battery switchover level |
| warnIntEn | input | 1 | Enables the power-fail interrupt |
| intClr | input | 1 | Write-one-to-clear for the interrupt flag |
| extRst | input | 1 | External reset pin, active high |
| ceIn | input | NUM_CE | Decoded chip enables from the core, active low |
| rwIn | input | 1 | Read/write strobe from the core |
| procReset | output | 1 | Reset hold to the processor |
| pfIrq | output | 1 | Power-fail interrupt request |
| pfVector | output | 8 | Interrupt vector, IRQ_VECTOR while pfIrq, else 0 |
| batSel | output | 1 | Selects the battery as supply source |
| ceOut | output | NUM_CE | Chip enables to memory, forced high in reset |
| rwOut | output | 1 | Read/write strobe to memory, forced high in reset |

## Verification
The bench builds the block with `POR_CYCLES`=16 and `NUM_CE`=4. It keeps the default vector 8'h2B. A 16-clock delay puts both edges of the power-on window within reach of a short run: the last cycle still held and the first cycle released. The same holds for a delay restarted by the external reset part-way through. Four enables, fed with a mixed pattern, show that forcing and pass-through act on every bit rather than on a single line.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  // Normalized supply severity, ordered from mild to worst
  typedef enum logic [1:0] {
    SEV_OK   = 2'd0,
    SEV_WARN = 2'd1,
    SEV_MIN  = 2'd2,
    SEV_BAT  = 2'd3
  } severity_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;    // reset cause present right now
    logic irqSet;  // warning interrupt should be set
  } pwrStrobes_t;

endpackage

// File: rtl/pwr_sup_ctrl.sv
module pwr_sup_ctrl
  import pwr_sup_pkg::*;
(
  input  logic        belowWarn,
  input  logic        belowMin,
  input  logic        belowBat,
  input  logic        warnIntEn,
  input  logic        extRst,
  input  logic        porDone,
  output pwrStrobes_t strb,
  output logic        batSel
);

  severity_e sev;

  // Priority encode: the worst flag wins, whatever the others say
  always_comb begin
    if (belowBat)       sev = SEV_BAT;
    else if (belowMin)  sev = SEV_MIN;
    else if (belowWarn) sev = SEV_WARN;
    else                sev = SEV_OK;
  end

  always_comb begin
    strb.hold   = extRst || (sev == SEV_MIN) || (sev == SEV_BAT);
    strb.irqSet = (sev == SEV_WARN) && warnIntEn && porDone && !extRst;
    batSel      = (sev == SEV_BAT);
  end

endmodule

// File: rtl/pwr_sup_datapath.sv
module pwr_sup_datapath
  import pwr_sup_pkg::*;
#(
  parameter int          POR_CYCLES = 21504,
  parameter int          NUM_CE     = 4,
  parameter logic [7:0]  IRQ_VECTOR = 8'h2B
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwrStrobes_t       strb,
  input  logic              intClr,
  input  logic [NUM_CE-1:0] ceIn,
  input  logic              rwIn,
  output logic              porDone,
  output logic              procReset,
  output logic              pfIrq,
  output logic [7:0]        pfVector,
  output logic [NUM_CE-1:0] ceOut,
  output logic              rwOut
);

  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(POR_CYCLES);

  logic [CNT_W-1:0] porCnt;
  logic             irqFlag;

  // Power-on delay: restarts on any hold cause, saturates at CNT_END
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 porCnt <= '0;
    else if (strb.hold)        porCnt <= '0;
    else if (porCnt != CNT_END) porCnt <= porCnt + CNT_W'(1);
  end

  assign porDone   = (porCnt == CNT_END);
  assign procReset = strb.hold || !porDone;

  // Sticky interrupt flag, set dominates clear, wiped during reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       irqFlag <= 1'b0;
    else if (strb.hold || !porDone)  irqFlag <= 1'b0;
    else                             irqFlag <= (irqFlag && !intClr) || strb.irqSet;
  end

  assign pfIrq    = irqFlag;
  assign pfVector = irqFlag ? IRQ_VECTOR : 8'h00;

  // Strobe forcing, one gate per enable line
  for (genvar i = 0; i < NUM_CE; i++) begin : g_ceForce
    assign ceOut[i] = procReset ? 1'b1 : ceIn[i];
  end
  assign rwOut = procReset ? 1'b1 : rwIn;

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int         POR_CYCLES = 21504,
  parameter int         NUM_CE     = 4,
  parameter logic [7:0] IRQ_VECTOR = 8'h2B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowWarn,
  input  logic              belowMin,
  input  logic              belowBat,
  input  logic              warnIntEn,
  input  logic              intClr,
  input  logic              extRst,
  input  logic [NUM_CE-1:0] ceIn,
  input  logic              rwIn,
  output logic              procReset,
  output logic              pfIrq,
  output logic [7:0]        pfVector,
  output logic              batSel,
  output logic [NUM_CE-1:0] ceOut,
  output logic              rwOut
);

  pwrStrobes_t strb;
  logic        porDone;

  pwr_sup_ctrl u_ctrl (
    .belowWarn (belowWarn),
    .belowMin  (belowMin),
    .belowBat  (belowBat),
    .warnIntEn (warnIntEn),
    .extRst    (extRst),
    .porDone   (porDone),
    .strb      (strb),
    .batSel    (batSel)
  );

  pwr_sup_datapath #(
    .POR_CYCLES (POR_CYCLES),
    .NUM_CE     (NUM_CE),
    .IRQ_VECTOR (IRQ_VECTOR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .intClr    (intClr),
    .ceIn      (ceIn),
    .rwIn      (rwIn),
    .porDone   (porDone),
    .procReset (procReset),
    .pfIrq     (pfIrq),
    .pfVector  (pfVector),
    .ceOut     (ceOut),
    .rwOut     (rwOut)
  );

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
  parameter int         NUM_CE     = 4,
  parameter logic [7:0] IRQ_VECTOR = 8'h2B
) (
  input logic              clk,
  input logic              rstN,
  input logic              belowMin,
  input logic              belowBat,
  input logic              warnIntEn,
  input logic              intClr,
  input logic              extRst,
  input logic              procReset,
  input logic              pfIrq,
  input logic [7:0]        pfVector,
  input logic              batSel,
  input logic [NUM_CE-1:0] ceOut,
  input logic              rwOut
);

  // R6
  ce_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    procReset |-> (&ceOut) && rwOut);

  // R5
  hold_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (belowMin || belowBat) |-> procReset);

  // R7
  bat_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    batSel == belowBat);

  // R2
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    pfIrq |-> pfVector == IRQ_VECTOR);

  // R4
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pfIrq && !intClr && !belowMin && !belowBat && !extRst) |=> pfIrq);

  // R3
  irq_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!warnIntEn && !pfIrq) |=> !pfIrq);

  // R8
  release_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(procReset) |-> !(belowMin || belowBat || extRst));

endmodule

bind pwr_supervisor pwr_supervisor_chk #(
  .NUM_CE     (NUM_CE),
  .IRQ_VECTOR (IRQ_VECTOR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .belowMin  (belowMin),
  .belowBat  (belowBat),
  .warnIntEn (warnIntEn),
  .intClr    (intClr),
  .extRst    (extRst),
  .procReset (procReset),
  .pfIrq     (pfIrq),
  .pfVector  (pfVector),
  .batSel    (batSel),
  .ceOut     (ceOut),
  .rwOut     (rwOut)
);

// File: tb/pwr_supervisor_test.sv
module pwr_supervisor_test;

  localparam int POR = 16;
  localparam int NCE = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           belowWarn = 1'b0, belowMin = 1'b0, belowBat = 1'b0;
  logic           warnIntEn = 1'b0, intClr = 1'b0, extRst = 1'b0;
  logic [NCE-1:0] ceIn = 4'b0101;
  logic           rwIn = 1'b0;
  logic           procReset, pfIrq, batSel, rwOut;
  logic [7:0]     pfVector;
  logic [NCE-1:0] ceOut;

  int testCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  pwr_supervisor #(.POR_CYCLES(POR), .NUM_CE(NCE), .IRQ_VECTOR(8'h2B)) uut (
    .clk(clk), .rstN(rstN), .belowWarn(belowWarn), .belowMin(belowMin),
    .belowBat(belowBat), .warnIntEn(warnIntEn), .intClr(intClr), .extRst(extRst),
    .ceIn(ceIn), .rwIn(rwIn), .procReset(procReset), .pfIrq(pfIrq),
    .pfVector(pfVector), .batSel(batSel), .ceOut(ceOut), .rwOut(rwOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // Called in the cycle where the last hold cause has just dropped (R8)
  task automatic checkPorRelease(input string tag);
    step(POR - 1);
    check({tag, " R8 held at N-1"}, procReset, 1);
    step(1);
    check({tag, " R8 released at N"}, procReset, 0);
    check({tag, " R6 ce pass"}, ceOut, ceIn);
    check({tag, " R6 rw pass"}, rwOut, rwIn);
  endtask

  task automatic testResetState();
    #1;
    check("R1 procReset", procReset, 1);
    check("R1 pfIrq", pfIrq, 0);
    check("R1 vector", pfVector, 0);
    check("R1 ceOut", ceOut, 4'hF);
    check("R1 rwOut", rwOut, 1);
    @(negedge clk); rstN = 1'b1;
    checkPorRelease("R1 startup");
  endtask

  task automatic testWarnIrq();
    warnIntEn = 1'b1; belowWarn = 1'b1; #1;
    check("R2 no irq before edge", pfIrq, 0);
    step(1);
    check("R2 irq raised", pfIrq, 1);
    check("R2 vector", pfVector, 8'h2B);
    check("R2 keeps running", procReset, 0);
    belowWarn = 1'b0;
    step(2);
    check("R4 sticky", pfIrq, 1);
    intClr = 1'b1;
    step(1);
    check("R4 cleared", pfIrq, 0);
    check("R3 vector zero", pfVector, 0);
    belowWarn = 1'b1;
    step(2);
    check("R4 set beats clear", pfIrq, 1);
    intClr = 1'b0; belowWarn = 1'b0;
    intClr = 1'b1; step(1); intClr = 1'b0;
  endtask

  task automatic testWarnDisabled();
    warnIntEn = 1'b0; belowWarn = 1'b1;
    step(3);
    check("R3 no irq", pfIrq, 0);
    check("R3 vector", pfVector, 0);
    belowWarn = 1'b0;
  endtask

  task automatic testMinAndBat();
    warnIntEn = 1'b1; belowWarn = 1'b1;
    step(1);
    check("R5 pre irq", pfIrq, 1);
    belowMin = 1'b1; #1;
    check("R5 immediate reset", procReset, 1);
    check("R6 ce forced", ceOut, 4'hF);
    check("R6 rw forced", rwOut, 1);
    check("R7 main rail", batSel, 0);
    step(1);
    check("R5 irq wiped", pfIrq, 0);
    belowBat = 1'b1; #1;
    check("R7 battery", batSel, 1);
    step(2);
    belowBat = 1'b0; #1;
    check("R7 back to main", batSel, 0);
    check("R5 still reset", procReset, 1);
    step(1);
    belowMin = 1'b0; belowWarn = 1'b0;
    checkPorRelease("R5");
    check("R5 no irq after", pfIrq, 0);
  endtask

  task automatic testExtReset();
    extRst = 1'b1; #1;
    check("R9 ext holds", procReset, 1);
    check("R9 ce forced", ceOut, 4'hF);
    step(2);
    extRst = 1'b0;
    step(POR - 4);
    check("R9 mid count", procReset, 1);
    extRst = 1'b1; step(1);
    extRst = 1'b0;
    checkPorRelease("R9 restart");
  endtask

  task automatic testOddOrder();
    belowBat = 1'b1; #1;
    check("R10 bat alone sel", batSel, 1);
    check("R10 bat alone reset", procReset, 1);
    step(1);
    belowBat = 1'b0;
    checkPorRelease("R10 bat");
    warnIntEn = 1'b1; belowMin = 1'b1; #1;
    check("R10 min alone reset", procReset, 1);
    check("R10 min alone no bat", batSel, 0);
    step(2);
    check("R10 min alone no irq", pfIrq, 0);
    belowMin = 1'b0;
    checkPorRelease("R10 min");
    warnIntEn = 1'b0;
  endtask

  initial begin
    fork
      begin
        testResetState();
        testWarnIrq();
        testWarnDisabled();
        ceIn = 4'b1010; rwIn = 1'b1;
        testMinAndBat();
        ceIn = 4'b0011; rwIn = 1'b0;
        testExtReset();
        testOddOrder();
      end
      begin
        repeat (20000) @(posedge clk);
        testCount++; failCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule